// File: doc/BRIEF.md
# USB Interrupt Aggregator with End-of-Interrupt Gate

This block sits between a USB on-the-go controller core and a processor. It gathers per-endpoint transmit and receive event pulses, eight core-level bus event pulses and a bus-power-drive event pulse into one sticky 32-bit pending register. Software reaches the block over a simple byte-addressed register bus. It can force pending bits high or low through separate write-one aliases. It can grow or shrink an enable mask through a second pair of aliases. It reads the pending bits that survive the mask from a dedicated address.

A single level interrupt line is raised while any enabled bit is pending and a service gate is open. When the processor reads the masked pending address while the line is high, the gate closes and the line falls. The line stays low until software writes the end-of-interrupt address, however many new events arrive in between. A control bit issues a one-cycle soft reset to the controller. That reset also empties the pending bits, the mask and the gate.

Top module: `usb_irq_aggregator`

## Requirements
- R1: The identity register at byte address 0x00 reads a fixed nonzero value (default 0x5A170001) in every cycle after reset.
- R2: Pending bit layout: transmit endpoints 0..4 on bits 4:0, receive endpoints 1..4 on bits 12:9, eight core events on bits 23:16 and the bus-power-drive event on bit 24; every other bit of the pending and mask registers always reads 0 and cannot be set.
- R3: An event input that is high at a clock edge sets its pending bit from the next cycle on, and the bit stays set after the input falls.
- R4: A write to 0x24 sets each pending bit whose data bit is 1, and a write to 0x28 clears each pending bit whose data bit is 1. Data bits of 0 leave the pending bits unchanged. The pending register reads at 0x20 from the cycle after the write.
- R5: When a clear write to 0x28 and an event for the same bit arrive at the same edge, the bit ends up set.
- R6: Writing 1s to 0x30 sets mask bits and writing 1s to 0x34 clears mask bits, with 0s having no effect. The mask reads back at 0x2C from the next cycle.
- R7: Address 0x38 reads the bitwise AND of the pending register and the mask.
- R8: The interrupt output is high exactly when the masked pending value is nonzero and the service gate is open. The gate is open out of reset.
- R9: A read of 0x38 while the interrupt output is high closes the gate. The output is then low from the next cycle until the cycle after a write of any data to 0x3C, and it stays low even as new enabled events arrive.
- R10: Writing 1 to bit 0 of 0x04 raises the soft-reset output for exactly one cycle. At the end of that cycle the pending register and the mask are cleared and the gate is opened. Bit 0 of 0x04 reads 0 once the pulse is over.
- R11: Bit 0 of the status register at 0x08 mirrors the bus-power-drive level input, and its other bits read 0.
- R12: Reads of the write-only aliases (0x24, 0x28, 0x30, 0x34, 0x3C) and of any unmapped address return 0, and a read bus returns 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| ev_tx | input | 5 | Transmit endpoint event pulses (endpoint 0..4) |
| ev_rx | input | 4 | Receive endpoint event pulses (endpoint 1..4) |
| ev_core | input | 8 | Core bus event pulses |
| ev_vbus | input | 1 | Bus-power-drive change event pulse |
| vbus_drive | input | 1 | Current bus-power-drive level |
| soft_rst | output | 1 | One-cycle reset pulse to the controller |
| irq | output | 1 | Level interrupt request |

## Verification
An event or a register write takes effect at the edge that samples it, so pending, mask and masked values are due on the read bus in the following cycle. The read data path is combinational, so a read is checked in the cycle its strobe is driven. The interrupt line and the soft-reset pulse are compared against a behavioural model on every cycle, half a period after each edge, once the model has taken in the same edge. The acknowledge, the end-of-interrupt reopen and the soft-reset clearing are therefore each checked in the first cycle after the causing edge, and again in the cycles after that.

// File: rtl/usb_irq_pkg.sv
// Shared address map and identity constant for the USB interrupt aggregator.
package usb_irq_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    // Byte offsets of the register map.
    localparam logic [ADDR_W-1:0] A_IDENT    = 8'h00;
    localparam logic [ADDR_W-1:0] A_CTRL     = 8'h04;
    localparam logic [ADDR_W-1:0] A_STATUS   = 8'h08;
    localparam logic [ADDR_W-1:0] A_PEND     = 8'h20;
    localparam logic [ADDR_W-1:0] A_PEND_SET = 8'h24;
    localparam logic [ADDR_W-1:0] A_PEND_CLR = 8'h28;
    localparam logic [ADDR_W-1:0] A_MASK     = 8'h2C;
    localparam logic [ADDR_W-1:0] A_MASK_SET = 8'h30;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 8'h34;
    localparam logic [ADDR_W-1:0] A_MASKED   = 8'h38;
    localparam logic [ADDR_W-1:0] A_EOI      = 8'h3C;

    localparam logic [DATA_W-1:0] IDENT_DEFAULT = 32'h5A17_0001;
endpackage

// File: rtl/irq_w1_reg.sv
// Register with write-one-to-set and write-one-to-clear inputs plus hardware
// set pulses. Hardware pulses and set bits win over clear bits at the same
// edge. A wipe input empties it with top priority. Bits outside KEEP stay 0.
// Assumes set/clear strobes are already qualified by the caller's decode.
module irq_w1_reg #(
    parameter int unsigned        W    = 32,
    parameter logic [W-1:0]       KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] hw_bits,
    output logic [W-1:0] q
);
    // Update: clear first, then OR in software sets and hardware events.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            q <= '0;
        end else begin
            q <= ((q & ~clr_bits) | set_bits | hw_bits) & KEEP;
        end
    end
endmodule

// File: rtl/irq_eoi_gate.sv
// Service gate for the interrupt line. The line follows the pending summary
// while the gate is open. An acknowledge while the line is high shuts the
// gate, and only an end-of-interrupt strobe or a wipe reopens it.
// Assumes ack and eoi never arrive in the same cycle (one bus access/cycle).
module irq_eoi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe,
    input  logic pending,
    input  logic ack,
    input  logic eoi,
    output logic irq
);
    logic gate_open;

    // Gate state: open out of reset, on wipe or EOI; shut on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            gate_open <= 1'b1;
        end else if (eoi) begin
            gate_open <= 1'b1;
        end else if (ack && irq) begin
            gate_open <= 1'b0;
        end
    end

    // Line drive: level request while gate open and something enabled pends.
    assign irq = gate_open && pending;
endmodule

// File: rtl/usb_irq_aggregator.sv
// Interrupt aggregator for a USB on-the-go core. Packs endpoint, core and
// bus-power-drive event pulses into a sticky pending register, applies an
// enable mask, and drives one level interrupt that must be released by an
// end-of-interrupt write after each service read.
// Assumes a single-cycle register bus: one access per cycle, reads
// combinational, writes taking effect at the sampling edge.
module usb_irq_aggregator
    import usb_irq_pkg::*;
#(
    parameter int unsigned        N_TX     = 5,
    parameter int unsigned        N_RX     = 4,
    parameter int unsigned        RX_LSB   = 9,
    parameter int unsigned        N_CORE   = 8,
    parameter int unsigned        CORE_LSB = 16,
    parameter logic [DATA_W-1:0]  IDENT    = IDENT_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_TX-1:0]   ev_tx,
    input  logic [N_RX-1:0]   ev_rx,
    input  logic [N_CORE-1:0] ev_core,
    input  logic              ev_vbus,
    input  logic              vbus_drive,
    output logic              soft_rst,
    output logic              irq
);
    localparam int unsigned VBUS_BIT = CORE_LSB + N_CORE;
    localparam logic [DATA_W-1:0] TX_FIELD   = (DATA_W'(1) << N_TX) - DATA_W'(1);
    localparam logic [DATA_W-1:0] RX_FIELD   = ((DATA_W'(1) << N_RX) - DATA_W'(1)) << RX_LSB;
    localparam logic [DATA_W-1:0] CORE_FIELD = ((DATA_W'(1) << N_CORE) - DATA_W'(1)) << CORE_LSB;
    localparam logic [DATA_W-1:0] VBUS_FIELD = DATA_W'(1) << VBUS_BIT;
    localparam logic [DATA_W-1:0] VALID_BITS = TX_FIELD | RX_FIELD | CORE_FIELD | VBUS_FIELD;

    logic              wr, rd;
    logic [DATA_W-1:0] ev_vec;
    logic [DATA_W-1:0] raw_q, mask_q;
    logic              soft_q;

    assign wr = bus_sel && bus_we;
    assign rd = bus_sel && !bus_we;

    // Event placement: one generate block per field puts pulses on their bits.
    for (genvar b = 0; b < DATA_W; b++) begin : g_ev
        if (b < N_TX) begin : g_tx
            assign ev_vec[b] = ev_tx[b];
        end else if (b >= RX_LSB && b < RX_LSB + N_RX) begin : g_rx
            assign ev_vec[b] = ev_rx[b - RX_LSB];
        end else if (b >= CORE_LSB && b < CORE_LSB + N_CORE) begin : g_core
            assign ev_vec[b] = ev_core[b - CORE_LSB];
        end else if (b == VBUS_BIT) begin : g_vbus
            assign ev_vec[b] = ev_vbus;
        end else begin : g_none
            assign ev_vec[b] = 1'b0;
        end
    end

    // Soft reset pulse: one cycle per control write with bit 0 high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else begin
            soft_q <= wr && (bus_addr == A_CTRL) && bus_wdata[0];
        end
    end
    assign soft_rst = soft_q;

    irq_w1_reg #(.W(DATA_W), .KEEP(VALID_BITS)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (soft_q),
        .set_bits ((wr && bus_addr == A_PEND_SET) ? bus_wdata : '0),
        .clr_bits ((wr && bus_addr == A_PEND_CLR) ? bus_wdata : '0),
        .hw_bits  (ev_vec),
        .q        (raw_q)
    );

    irq_w1_reg #(.W(DATA_W), .KEEP(VALID_BITS)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (soft_q),
        .set_bits ((wr && bus_addr == A_MASK_SET) ? bus_wdata : '0),
        .clr_bits ((wr && bus_addr == A_MASK_CLR) ? bus_wdata : '0),
        .hw_bits  ('0),
        .q        (mask_q)
    );

    irq_eoi_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (soft_q),
        .pending (|(raw_q & mask_q)),
        .ack     (rd && bus_addr == A_MASKED),
        .eoi     (wr && bus_addr == A_EOI),
        .irq     (irq)
    );

    // Read mux: readable registers by address; aliases and holes read 0.
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                A_IDENT:  bus_rdata = IDENT;
                A_CTRL:   bus_rdata = {{(DATA_W-1){1'b0}}, soft_q};
                A_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, vbus_drive};
                A_PEND:   bus_rdata = raw_q;
                A_MASK:   bus_rdata = mask_q;
                A_MASKED: bus_rdata = raw_q & mask_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/usb_irq_checker.sv
// Property checker for the USB interrupt aggregator, attached by bind.
// Observes ports plus the pending and mask registers of the top.
module usb_irq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [4:0]  ev_tx,
    input logic        soft_rst,
    input logic        irq,
    input logic [31:0] raw_q,
    input logic [31:0] mask_q,
    input logic [31:0] valid_bits
);
    logic ack, eoi, closed;
    assign ack = bus_sel && !bus_we && bus_addr == 8'h38;
    assign eoi = bus_sel && bus_we && bus_addr == 8'h3C;

    // Independent record of a served-but-not-released interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || eoi) closed <= 1'b0;
        else if (ack && irq)           closed <= 1'b1;
    end

    p_ident_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 8'h00) |-> bus_rdata != 32'd0);
    p_spare_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q | mask_q) & ~valid_bits) == 32'd0);
    p_event_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx[0] && !soft_rst) |=> raw_q[0]);
    p_event_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx[0] && !soft_rst && bus_sel && bus_we && bus_addr == 8'h28 && bus_wdata[0])
        |=> raw_q[0]);
    p_irq_needs_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_q & mask_q) != 32'd0);
    p_ack_drops_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !soft_rst) |=> !irq);
    p_held_until_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        closed |-> !irq);
    p_soft_wipes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (raw_q == 32'd0 && mask_q == 32'd0));
endmodule

bind usb_irq_aggregator usb_irq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ev_tx      (ev_tx),
    .soft_rst   (soft_rst),
    .irq        (irq),
    .raw_q      (raw_q),
    .mask_q     (mask_q),
    .valid_bits (VALID_BITS)
);

// File: tb/test_usb_irq_aggregator.sv
module test_usb_irq_aggregator;
    localparam logic [31:0] VALID = 32'h01FF_1E1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [4:0]  ev_tx = '0;
    logic [3:0]  ev_rx = '0;
    logic [7:0]  ev_core = '0;
    logic        ev_vbus = 1'b0, vbus_drive = 1'b0;
    logic        soft_rst, irq;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    usb_irq_aggregator i_usb_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_core(ev_core), .ev_vbus(ev_vbus),
        .vbus_drive(vbus_drive), .soft_rst(soft_rst), .irq(irq)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Behavioural reference state, advanced at each rising edge.
    logic [31:0] m_raw = '0, m_mask = '0;
    bit m_gate = 1'b1, m_soft = 1'b0;

    always @(posedge clk) begin
        logic [31:0] evv;
        bit w, r, line;
        evv = {7'b0, ev_vbus, ev_core, 3'b0, ev_rx, 4'b0, ev_tx};
        w = bus_sel && bus_we;
        r = bus_sel && !bus_we;
        if (!rst_n || m_soft) begin
            m_raw = '0; m_mask = '0; m_gate = 1'b1; m_soft = 1'b0;
        end else begin
            line = m_gate && ((m_raw & m_mask) != 0);
            if (w && bus_addr == 8'h28) m_raw = m_raw & ~bus_wdata;
            if (w && bus_addr == 8'h24) m_raw = m_raw | bus_wdata;
            m_raw = (m_raw | evv) & VALID;
            if (w && bus_addr == 8'h34) m_mask = m_mask & ~bus_wdata;
            if (w && bus_addr == 8'h30) m_mask = m_mask | bus_wdata;
            m_mask = m_mask & VALID;
            if (w && bus_addr == 8'h3C) m_gate = 1'b1;
            else if (r && bus_addr == 8'h38 && line) m_gate = 1'b0;
            m_soft = w && bus_addr == 8'h04 && bus_wdata[0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Every-cycle comparison of line outputs against the model (R8, R9, R10).
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8/R9 irq vs model", {31'b0, irq}, {31'b0, m_gate && ((m_raw & m_mask) != 0)});
            chk("R10 soft_rst vs model", {31'b0, soft_rst}, {31'b0, m_soft});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        #1 chk("R12 idle read bus zero", bus_rdata, 32'h0);
        // R1: identity nonzero; reset state empty.
        @(negedge clk); bus_sel = 1'b1; bus_addr = 8'h00;
        #1 checks++;
        if (bus_rdata == 32'h0) begin fails++; $display("FAIL R1 ident: actual %h expected nonzero", bus_rdata); end
        @(negedge clk); bus_sel = 1'b0;
        rd(8'h20, 32'h0, "R3 pending after reset");
        rd(8'h2C, 32'h0, "R6 mask after reset");
        rd(8'h38, 32'h0, "R7 masked after reset");

        // R2/R3: one event per field lands on its bit and sticks.
        @(negedge clk);
        ev_tx = 5'b00100; ev_rx = 4'b1000; ev_core = 8'h20; ev_vbus = 1'b1;
        @(negedge clk);
        ev_tx = '0; ev_rx = '0; ev_core = '0; ev_vbus = 1'b0;
        rd(8'h20, 32'h0120_1004, "R2 field placement");
        idle(4);
        rd(8'h20, 32'h0120_1004, "R3 sticky pending");

        // R4/R2: write-one aliases and zero writes.
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R4 clear all");
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h20, VALID, "R2 only defined bits settable");
        wr(8'h24, 32'h0);
        wr(8'h28, 32'h0);
        rd(8'h20, VALID, "R4 zero data no effect");
        wr(8'h28, 32'h01FF_0000);
        rd(8'h20, 32'h0000_1E1F, "R4 partial clear");

        // R5: clear and event on bit 1 at the same edge.
        wr(8'h28, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h0000_0002; ev_tx = 5'b00010;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; ev_tx = '0;
        rd(8'h20, 32'h0000_0002, "R5 event wins over clear");

        // R6: mask aliases.
        wr(8'h30, 32'h0000_0006);
        chk("R8 irq high with enabled pending", {31'b0, irq}, 32'h1);
        rd(8'h2C, 32'h0000_0006, "R6 mask set");
        wr(8'h34, 32'h0000_0004);
        rd(8'h2C, 32'h0000_0002, "R6 mask clear");

        // R7/R9: service read acknowledges, EOI releases.
        rd(8'h38, 32'h0000_0002, "R7 masked read");
        chk("R9 irq low after service read", {31'b0, irq}, 32'h0);
        @(negedge clk); ev_tx = 5'b00001; @(negedge clk); ev_tx = '0;
        wr(8'h30, 32'h0000_0001);
        idle(2);
        chk("R9 irq held low before EOI", {31'b0, irq}, 32'h0);
        rd(8'h38, 32'h0000_0003, "R7 masked two bits");
        wr(8'h3C, 32'h0);
        chk("R9 irq back after EOI", {31'b0, irq}, 32'h1);
        wr(8'h34, 32'hFFFF_FFFF);
        chk("R8 irq low when masked off", {31'b0, irq}, 32'h0);
        rd(8'h38, 32'h0, "R7 masked off reads zero");

        // R11: status mirror.
        vbus_drive = 1'b1;
        rd(8'h08, 32'h1, "R11 status high");
        vbus_drive = 1'b0;
        rd(8'h08, 32'h0, "R11 status low");

        // R12: aliases and holes read zero.
        rd(8'h24, 32'h0, "R12 set alias read");
        rd(8'h30, 32'h0, "R12 mask set alias read");
        rd(8'h3C, 32'h0, "R12 eoi read");
        rd(8'h40, 32'h0, "R12 unmapped read");

        // R10: soft reset wipes pending, mask and a shut gate.
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h24, 32'h0000_00FF);
        wr(8'h30, 32'h0000_00FF);
        rd(8'h38, 32'h0000_001F, "R7 masked before soft reset");
        chk("R9 gate shut before soft reset", {31'b0, irq}, 32'h0);
        wr(8'h04, 32'h1);
        chk("R10 soft reset pulse", {31'b0, soft_rst}, 32'h1);
        rd(8'h04, 32'h0, "R10 control self-clears");
        rd(8'h20, 32'h0, "R10 pending wiped");
        rd(8'h2C, 32'h0, "R10 mask wiped");
        wr(8'h24, 32'h0000_0001);
        wr(8'h30, 32'h0000_0001);
        chk("R10 gate reopened without EOI", {31'b0, irq}, 32'h1);
        idle(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule